// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a first-level, read-only cache of the kind used for instruction fetch. It pairs a direct-mapped array with a small fully-associative side buffer on the refill path. The side buffer absorbs conflict misses: two lines that fight over one set can both stay on chip. A main-array miss that finds its line in the side buffer costs one extra cycle and no memory traffic.

The processor presents one line address at a time on a valid/ready port. It receives the line data and two flags that tell where the line was found. When neither structure holds the line, the block raises a memory request with the line address and holds it until the memory returns the line, which may take any number of cycles. A parameter selects how the side buffer is filled. In victim mode, a refill pushes the line evicted from the main array into the buffer, and a buffer hit swaps the two lines. In miss mode, every refilled line is copied into both structures. Three saturating counters report main-array hits, side-buffer hits and full misses.

Top module: `dm_victim_cache`

## Requirements
- R1: A request accepted (req_valid and req_ready high at a clock edge) that hits the main array returns rsp_valid in the next cycle with rsp_hit=1, rsp_side=0, and issues no memory request.
- R2: A request that misses the main array but hits the side buffer returns rsp_valid two cycles after acceptance with rsp_hit=0, rsp_side=1, and issues no memory request.
- R3: A request that misses both structures raises mem_req with mem_addr equal to the line address and holds both stable until mem_rsp_valid. The response (rsp_hit=0, rsp_side=0) follows in the next cycle, and req_ready stays low until then.
- R4: In victim mode, a refill moves the valid line it displaces from the main array into the side buffer. The refilled line itself is not placed there.
- R5: In victim mode, a side-buffer hit swaps lines: the hit line moves into the main array and the displaced main-array line takes over the same buffer slot.
- R6: In miss mode, a refilled line is written to both the main array and the side buffer. A side-buffer hit copies the line into the main array and keeps it in the buffer.
- R7: A line is inserted into an invalid side-buffer slot if one exists. Otherwise it replaces the least recently used slot, where a hit or an insertion makes a slot most recent.
- R8: A reset of one clock cycle invalidates every main-array line and side-buffer entry, clears the counters, and leaves req_ready=1, rsp_valid=0 and mem_req=0.
- R9: cnt_hit, cnt_side and cnt_miss count main hits, side hits and full misses. Each counter saturates at its all-ones value.
- R10: rsp_data equals the data that memory returned for the requested line address, whichever structure supplies it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request valid |
| req_addr | input | ADDR_W | Requested line address |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Line came from the main array |
| rsp_side | output | 1 | Line came from the side buffer |
| rsp_data | output | DATA_W | Line data |
| mem_req | output | 1 | Refill request to memory |
| mem_addr | output | ADDR_W | Line address of the refill |
| mem_rsp_valid | input | 1 | Refill data valid |
| mem_rsp_data | input | DATA_W | Refill line data |
| cnt_hit | output | CNT_W | Main-array hit count |
| cnt_side | output | CNT_W | Side-buffer hit count |
| cnt_miss | output | CNT_W | Full-miss count |

## Verification
A corrupt tag, valid bit or data word in either structure does not show up at once. It appears on the next request for the affected line, as wrong rsp_data, the wrong flag, the wrong latency, or a memory request where none was due (or the reverse). A wrong LRU order stays hidden until a full buffer evicts a line that is later requested again. For that reason the stimulus fills the buffer, forces evictions, and then revisits both the surviving lines and the evicted ones. The counters shift by one at every misclassified access, so they expose a miscount within that same access.

// File: rtl/dm_victim_cache.sv
module dm_victim_cache #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 3,
  parameter int VB_DEPTH    = 2,
  parameter bit VICTIM_MODE = 1'b1,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_side,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [CNT_W-1:0]  cnt_hit,
  output logic [CNT_W-1:0]  cnt_side,
  output logic [CNT_W-1:0]  cnt_miss
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int AGE_W = (VB_DEPTH > 1) ? $clog2(VB_DEPTH) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_FILL} st_t;
  st_t state;

  logic [SETS-1:0]     m_val;
  logic [TAG_W-1:0]    m_tag [SETS];
  logic [DATA_W-1:0]   m_dat [SETS];
  logic [VB_DEPTH-1:0] v_val;
  logic [ADDR_W-1:0]   v_addr [VB_DEPTH];
  logic [DATA_W-1:0]   v_dat  [VB_DEPTH];
  logic [AGE_W-1:0]    v_age  [VB_DEPTH];
  logic [ADDR_W-1:0]   q_addr;

  wire [IDX_W-1:0]  in_idx = req_addr[IDX_W-1:0];
  wire [IDX_W-1:0]  q_idx  = q_addr[IDX_W-1:0];
  wire [TAG_W-1:0]  q_tag  = q_addr[ADDR_W-1:IDX_W];
  wire              main_hit = m_val[in_idx] && (m_tag[in_idx] == req_addr[ADDR_W-1:IDX_W]);
  wire [ADDR_W-1:0] evict_addr = {m_tag[q_idx], q_idx};

  assign req_ready = (state == ST_IDLE);
  assign mem_req   = (state == ST_FILL);
  assign mem_addr  = q_addr;

  logic             v_hit, free_found;
  logic [AGE_W-1:0] v_sel, r_sel;

  always_comb begin
    v_hit = 1'b0;
    v_sel = '0;
    for (int i = 0; i < VB_DEPTH; i++)
      if (v_val[i] && v_addr[i] == q_addr) begin
        v_hit = 1'b1;
        v_sel = AGE_W'(i);
      end
  end

  always_comb begin
    r_sel = '0;
    free_found = 1'b0;
    for (int i = 0; i < VB_DEPTH; i++)
      if (!v_val[i] && !free_found) begin
        r_sel = AGE_W'(i);
        free_found = 1'b1;
      end
    if (!free_found)
      for (int i = 0; i < VB_DEPTH; i++)
        if (v_age[i] == AGE_W'(VB_DEPTH - 1)) r_sel = AGE_W'(i);
  end

  wire side_done = (state == ST_LOOK) && v_hit;
  wire fill_done = (state == ST_FILL) && mem_rsp_valid;
  wire fill_ins  = fill_done && (!VICTIM_MODE || m_val[q_idx]);
  wire touch_en  = side_done || fill_ins;
  wire [AGE_W-1:0] touch_sel = side_done ? v_sel : r_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      m_val     <= '0;
      v_val     <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_side  <= 1'b0;
      cnt_hit   <= '0;
      cnt_side  <= '0;
      cnt_miss  <= '0;
      for (int i = 0; i < VB_DEPTH; i++) v_age[i] <= AGE_W'(i);
    end else begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_side  <= 1'b0;
      if (touch_en)
        for (int i = 0; i < VB_DEPTH; i++)
          if (AGE_W'(i) == touch_sel) v_age[i] <= '0;
          else if (v_age[i] < v_age[touch_sel]) v_age[i] <= v_age[i] + 1'b1;
      case (state)
        ST_IDLE: if (req_valid) begin
          q_addr <= req_addr;
          if (main_hit) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_data  <= m_dat[in_idx];
            cnt_hit   <= cnt_hit + {{(CNT_W-1){1'b0}}, ~&cnt_hit};
          end else state <= ST_LOOK;
        end
        ST_LOOK: if (v_hit) begin
          rsp_valid      <= 1'b1;
          rsp_side       <= 1'b1;
          rsp_data       <= v_dat[v_sel];
          m_val[q_idx]   <= 1'b1;
          m_tag[q_idx]   <= q_tag;
          m_dat[q_idx]   <= v_dat[v_sel];
          cnt_side       <= cnt_side + {{(CNT_W-1){1'b0}}, ~&cnt_side};
          if (VICTIM_MODE) begin
            v_val[v_sel]  <= m_val[q_idx];
            v_addr[v_sel] <= evict_addr;
            v_dat[v_sel]  <= m_dat[q_idx];
          end
          state <= ST_IDLE;
        end else begin
          cnt_miss <= cnt_miss + {{(CNT_W-1){1'b0}}, ~&cnt_miss};
          state    <= ST_FILL;
        end
        ST_FILL: if (mem_rsp_valid) begin
          rsp_valid    <= 1'b1;
          rsp_data     <= mem_rsp_data;
          m_val[q_idx] <= 1'b1;
          m_tag[q_idx] <= q_tag;
          m_dat[q_idx] <= mem_rsp_data;
          if (fill_ins) begin
            v_val[r_sel]  <= 1'b1;
            v_addr[r_sel] <= VICTIM_MODE ? evict_addr : q_addr;
            v_dat[r_sel]  <= VICTIM_MODE ? m_dat[q_idx] : mem_rsp_data;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  main_hit_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> $past(req_valid && req_ready));
  // R2
  side_hit_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_side |-> $past(req_valid && req_ready, 2) && !$past(mem_req));
  // R3
  refill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rsp_valid |=> mem_req && $stable(mem_addr) && !req_ready);
  // R3
  flag_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_hit, rsp_side}) && ((rsp_hit || rsp_side) -> rsp_valid));
  // R8
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> req_ready && !rsp_valid && !mem_req && cnt_hit == '0 && cnt_side == '0 && cnt_miss == '0);
  // R9
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt_hit >= $past(cnt_hit) && cnt_side >= $past(cnt_side) && cnt_miss >= $past(cnt_miss));
endmodule

// File: tb/dm_victim_cache_tb_top.sv
module dm_victim_cache_tb_top;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int K_HIT = 0, K_SIDE = 1, K_MISS = 2;

  typedef struct {
    logic [AW-1:0] addr;
    int            kind;
    int            t0;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [1:0]         req_valid;
  logic [1:0][AW-1:0] req_addr;
  logic [1:0]         req_ready, rsp_valid, rsp_hit, rsp_side, mem_req;
  logic [1:0][DW-1:0] rsp_data;
  logic [1:0][AW-1:0] mem_addr;
  logic [31:0] c_hit0, c_side0, c_miss0;
  logic [3:0]  c_hit1, c_side1, c_miss1;

  int total = 0, bad = 0;
  exp_t q0[$];
  exp_t q1[$];

  function automatic logic [DW-1:0] fdat(logic [AW-1:0] a);
    return {a, 8'h5c, ~a};
  endfunction

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  for (genvar g = 0; g < 2; g++) begin : mem_g
    logic rv = 1'b0;
    logic [DW-1:0] rd = '0;
    int waitc = 0, lat = 1, nreq = 0;
    always @(negedge clk) begin
      rv <= 1'b0;
      if (mem_req[g] && !rv) begin
        if (waitc >= lat) begin
          rv <= 1'b1;
          rd <= fdat(mem_addr[g]);
          waitc = 0;
          nreq++;
          lat = (lat + 3) % 7;
        end else waitc++;
      end
    end
  end

  dm_victim_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(3), .VB_DEPTH(2), .VICTIM_MODE(1'b1), .CNT_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_addr(req_addr[0]), .req_ready(req_ready[0]),
    .rsp_valid(rsp_valid[0]), .rsp_hit(rsp_hit[0]), .rsp_side(rsp_side[0]), .rsp_data(rsp_data[0]),
    .mem_req(mem_req[0]), .mem_addr(mem_addr[0]), .mem_rsp_valid(mem_g[0].rv), .mem_rsp_data(mem_g[0].rd),
    .cnt_hit(c_hit0), .cnt_side(c_side0), .cnt_miss(c_miss0));

  dm_victim_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(3), .VB_DEPTH(2), .VICTIM_MODE(1'b0), .CNT_W(4)) dut_m (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_addr(req_addr[1]), .req_ready(req_ready[1]),
    .rsp_valid(rsp_valid[1]), .rsp_hit(rsp_hit[1]), .rsp_side(rsp_side[1]), .rsp_data(rsp_data[1]),
    .mem_req(mem_req[1]), .mem_addr(mem_addr[1]), .mem_rsp_valid(mem_g[1].rv), .mem_rsp_data(mem_g[1].rd),
    .cnt_hit(c_hit1), .cnt_side(c_side1), .cnt_miss(c_miss1));

  for (genvar g = 0; g < 2; g++) begin : mon_g
    always @(negedge clk) begin : mon
      exp_t e;
      int lat;
      if (rst_n && rsp_valid[g]) begin
        if ((g == 0 ? q0.size() : q1.size()) == 0) chk(1'b0, "R1", "response with no request", 1, 0);
        else begin
          if (g == 0) e = q0.pop_front();
          else e = q1.pop_front();
          lat = cyc - e.t0;
          chk(rsp_data[g] == fdat(e.addr), "R10", "rsp_data", rsp_data[g], fdat(e.addr));
          chk(rsp_hit[g] == (e.kind == K_HIT), e.tag, "rsp_hit", rsp_hit[g], e.kind == K_HIT);
          chk(rsp_side[g] == (e.kind == K_SIDE), e.tag, "rsp_side", rsp_side[g], e.kind == K_SIDE);
          if (e.kind == K_HIT)  chk(lat == 1, "R1", "hit latency", lat, 1);
          if (e.kind == K_SIDE) chk(lat == 2, "R2", "side latency", lat, 2);
          if (e.kind == K_MISS) chk(lat >= 3, "R3", "miss latency", lat, 3);
        end
      end
    end
  end

  function automatic int nreq_of(int d);
    return (d == 0) ? mem_g[0].nreq : mem_g[1].nreq;
  endfunction

  task automatic access(int d, logic [AW-1:0] a, int kind, string tag);
    exp_t e;
    int n0;
    n0 = nreq_of(d);
    @(negedge clk);
    req_valid[d] = 1'b1;
    req_addr[d]  = a;
    while (!req_ready[d]) @(negedge clk);
    e.addr = a; e.kind = kind; e.t0 = cyc; e.tag = tag;
    if (d == 0) q0.push_back(e); else q1.push_back(e);
    @(negedge clk);
    req_valid[d] = 1'b0;
    while ((d == 0 ? q0.size() : q1.size()) != 0) @(negedge clk);
    if (kind == K_MISS) chk(nreq_of(d) == n0 + 1, "R3", "one memory request on miss", nreq_of(d) - n0, 1);
    else chk(nreq_of(d) == n0, kind == K_HIT ? "R1" : "R2", "no memory request", nreq_of(d) - n0, 0);
  endtask

  bit done = 1'b0;
  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [AW-1:0] LA = 12'h010, LB = 12'h020, LC = 12'h030, LD = 12'h040, LE = 12'h011;

  initial begin
    req_valid = '0;
    req_addr  = '0;
    repeat (3) @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk(req_ready[d] && !rsp_valid[d] && !mem_req[d], "R8", "port state in reset", {req_ready[d], rsp_valid[d], mem_req[d]}, 3'b100);
    end
    chk(c_hit0 == 0 && c_side0 == 0 && c_miss0 == 0, "R8", "counters in reset", c_hit0 + c_side0 + c_miss0, 0);
    rst_n = 1'b1;

    // victim mode
    access(0, LA, K_MISS, "R3");
    access(0, LA, K_HIT,  "R1");
    access(0, LB, K_MISS, "R4");
    access(0, LB, K_HIT,  "R1");
    access(0, LA, K_SIDE, "R4");
    access(0, LA, K_HIT,  "R5");
    access(0, LB, K_SIDE, "R5");
    access(0, LC, K_MISS, "R7");
    access(0, LD, K_MISS, "R7");
    access(0, LA, K_MISS, "R7");
    access(0, LC, K_SIDE, "R7");
    access(0, LB, K_MISS, "R7");
    access(0, LE, K_MISS, "R3");
    access(0, LE, K_HIT,  "R1");
    chk(c_hit0 == 4,  "R9", "victim cnt_hit", c_hit0, 4);
    chk(c_side0 == 3, "R9", "victim cnt_side", c_side0, 3);
    chk(c_miss0 == 7, "R9", "victim cnt_miss", c_miss0, 7);

    // miss mode
    access(1, LA, K_MISS, "R6");
    access(1, LA, K_HIT,  "R1");
    access(1, LB, K_MISS, "R7");
    access(1, LA, K_SIDE, "R6");
    access(1, LB, K_SIDE, "R6");
    access(1, LA, K_SIDE, "R6");
    access(1, LC, K_MISS, "R7");
    access(1, LB, K_MISS, "R7");
    access(1, LA, K_MISS, "R7");
    for (int k = 0; k < 20; k++) access(1, LA, K_HIT, "R9");
    chk(c_hit1 == 4'hf, "R9", "saturated cnt_hit", c_hit1, 15);
    chk(c_side1 == 3,   "R9", "miss-mode cnt_side", c_side1, 3);
    chk(c_miss1 == 5,   "R9", "miss-mode cnt_miss", c_miss1, 5);

    // single-cycle reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk(c_hit0 == 0 && c_side0 == 0 && c_miss0 == 0, "R8", "victim counters after reset", c_hit0 + c_side0 + c_miss0, 0);
    chk(c_hit1 == 0 && c_side1 == 0 && c_miss1 == 0, "R8", "miss-mode counters after reset", c_hit1 + c_side1 + c_miss1, 0);
    access(0, LE, K_MISS, "R8");
    access(0, LC, K_MISS, "R8");
    access(1, LA, K_MISS, "R8");
    access(1, LB, K_MISS, "R8");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule